// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block gathers sector-erase requests into one parallel erase. The first sector-erase strobe opens a collection window, and that sector becomes the first bit of a pending mask. Each later strobe that arrives before the window runs out adds its sector to the mask and restarts the window from zero. When the window has gone a full `WIN` cycles with no new strobe, the block commits the erase. It raises a one-cycle commit pulse, presents the mask to the erase engine, and sets its window-expired status bit. It then stays busy until the engine reports that the erase is done.

A write that is not a sector-erase code, received while the window is open, cancels the collection and throws the mask away. The erase engine works alone: it pre-programs each byte of the chosen sectors to 00h and then erases them to FFh. During that time the block ignores all further requests. The window length is a parameter counted in clock cycles. Its default is 25000, which is 100 us at a 250 MHz clock.

Top module: `sector_erase_accum`

## Requirements
- R1: After reset, `busy`, `window_expired`, `commit` and `erase_mask` are all 0.
- R2: In idle, a strobe on `se_valid` starts a collection on the next clock: `busy` is 1, `window_expired` is 0, and `erase_mask` holds only the bit for `se_sector` (bit i stands for sector i).
- R3: Every further strobe accepted during the collection ORs its sector bit into `erase_mask`.
- R4: The commit comes exactly `WIN` clock edges after the edge that sampled the last accepted strobe. A strobe accepted at any point in the window, including its last cycle, restarts the count.
- R5: `window_expired` is 0 while the window is counting. It is 1 from the commit cycle until the erase completes, and `busy` is 1 whenever it is 1.
- R6: `commit` is a single-cycle pulse. It appears in the first cycle that `window_expired` is 1, and during that cycle `erase_mask` equals the OR of all accepted sector bits.
- R7: While the erase runs, `se_valid` and `other_wr` have no effect: `erase_mask`, `window_expired` and `busy` stay unchanged.
- R8: `eng_done` during the erase returns the block to idle on the next clock, with `busy`, `window_expired` and `erase_mask` all 0.
- R9: `other_wr` during the collection returns the block to idle on the next clock with the mask cleared, and no commit follows. It wins over a `se_valid` in the same cycle.
- R10: In idle, `other_wr` has no effect. In idle, and during the collection, `eng_done` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| se_valid | input | 1 | One-cycle sector-erase code strobe |
| se_sector | input | SEC_W | Sector index carried with the strobe |
| other_wr | input | 1 | Write cycle that is not a sector-erase code |
| eng_done | input | 1 | Erase engine completion pulse |
| busy | output | 1 | High while collecting or erasing |
| window_expired | output | 1 | Status bit: 0 while the window counts, 1 once the erase is under way |
| commit | output | 1 | One-cycle pulse at window expiry |
| erase_mask | output | N_SEC | Pending, then committed, sector mask |

## Verification
The bench uses eight sectors and a five-cycle window. It builds every non-empty sector mask by strobing each of the mask's sectors in turn. The gap between strobes depends on the mask and runs from back-to-back up to the window's last cycle, so masks that differ only by a single bit, or only in timing, are told apart by the committed mask. They are also told apart by the exact cycle of the commit. A second sweep cancels the collection at each position in the window, with and without a strobe in the same cycle. This separates a lost cancel from a commit that comes too early or too late. Directed runs check that engine completion and foreign writes are ignored in the states where they must be.

// File: rtl/se_acc_pkg.sv
package se_acc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_ERASE   = 2'd2
  } acc_state_e;
endpackage

// File: rtl/se_win_timer.sv
// Restartable window counter: expire fires on the cycle the window would
// reach its length with no restart pending.
module se_win_timer #(
  parameter int WIN = 25000,
  localparam int CW = (WIN > 2) ? $clog2(WIN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = run && !restart && (cnt_q == CW'(WIN - 1));

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (restart) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run && !expire) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/se_mask_acc.sv
// Pending sector mask: one bit per sector, OR-accumulated, cleared on demand.
module se_mask_acc #(
  parameter int N_SEC = 8,
  localparam int SEC_W = (N_SEC > 1) ? $clog2(N_SEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add,
  input  logic [SEC_W-1:0] sector,
  input  logic             clear,
  output logic [N_SEC-1:0] mask
);
  logic [N_SEC-1:0] mask_d;
  logic [N_SEC-1:0] sel;
  logic             mask_en;

  for (genvar i = 0; i < N_SEC; i++) begin : g_dec
    assign sel[i] = (sector == SEC_W'(i));
  end

  always_comb begin
    mask_en = clear || add;
    mask_d  = mask;
    if (clear)    mask_d = '0;
    else if (add) mask_d = mask | sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_en) mask <= mask_d;
  end
endmodule

// File: rtl/se_acc_fsm.sv
// Sequencer: idle -> collect -> erase -> idle, with cancel from collect.
module se_acc_fsm
  import se_acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       se_valid,
  input  logic       other_wr,
  input  logic       expire,
  input  logic       eng_done,
  output acc_state_e state,
  output logic       accept,
  output logic       clear,
  output logic       commit_q
);
  acc_state_e state_d;
  logic       commit_d;
  logic       cancel;
  logic       finish;

  assign cancel = (state == ST_COLLECT) && other_wr;
  assign finish = (state == ST_ERASE) && eng_done;
  assign accept = se_valid &&
                  ((state == ST_IDLE) || ((state == ST_COLLECT) && !other_wr));
  assign clear  = cancel || finish;

  always_comb begin
    state_d  = state;
    commit_d = 1'b0;
    unique case (state)
      ST_IDLE:    if (accept) state_d = ST_COLLECT;
      ST_COLLECT: begin
        if (cancel) state_d = ST_IDLE;
        else if (expire) begin
          state_d  = ST_ERASE;
          commit_d = 1'b1;
        end
      end
      ST_ERASE:   if (finish) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      commit_q <= 1'b0;
    end else begin
      state    <= state_d;
      commit_q <= commit_d;
    end
  end
endmodule

// File: rtl/sector_erase_accum.sv
module sector_erase_accum
  import se_acc_pkg::*;
#(
  parameter int N_SEC = 8,
  parameter int WIN   = 25000,
  localparam int SEC_W = (N_SEC > 1) ? $clog2(N_SEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se_valid,
  input  logic [SEC_W-1:0] se_sector,
  input  logic             other_wr,
  input  logic             eng_done,
  output logic             busy,
  output logic             window_expired,
  output logic             commit,
  output logic [N_SEC-1:0] erase_mask
);
  acc_state_e state;
  logic       accept;
  logic       clear;
  logic       expire;
  logic       run;

  assign run = (state == ST_COLLECT) && !other_wr;

  se_acc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .se_valid (se_valid),
    .other_wr (other_wr),
    .expire   (expire),
    .eng_done (eng_done),
    .state    (state),
    .accept   (accept),
    .clear    (clear),
    .commit_q (commit)
  );

  se_win_timer #(.WIN(WIN)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (accept),
    .expire  (expire)
  );

  se_mask_acc #(.N_SEC(N_SEC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .add    (accept),
    .sector (se_sector),
    .clear  (clear),
    .mask   (erase_mask)
  );

  assign busy           = (state != ST_IDLE);
  assign window_expired = (state == ST_ERASE);
endmodule

// File: rtl/se_acc_chk.sv
module se_acc_chk #(
  parameter int N_SEC = 8,
  parameter int WIN   = 25000,
  localparam int SEC_W = (N_SEC > 1) ? $clog2(N_SEC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             se_valid,
  input logic [SEC_W-1:0] se_sector,
  input logic             other_wr,
  input logic             eng_done,
  input logic             busy,
  input logic             window_expired,
  input logic             commit,
  input logic [N_SEC-1:0] erase_mask
);
  int  gap_q;
  logic took;
  assign took = se_valid && (!busy || (!window_expired && !other_wr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= 0;
    else if (took)                     gap_q <= 0;
    else if (busy && !window_expired)  gap_q <= gap_q + 1;
  end

  AST_IDLE_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (erase_mask == '0)); // R1
  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && se_valid) |=> (busy && !window_expired && erase_mask[$past(se_sector)])); // R2
  AST_COMMIT_DISTANCE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (gap_q == WIN)); // R4
  AST_FLAG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    window_expired |-> busy); // R5
  AST_COMMIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R6
  AST_COMMIT_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_expired) |-> commit); // R6
  AST_COMMIT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (window_expired && erase_mask != '0)); // R6
  AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (window_expired && !eng_done) |=> (window_expired && $stable(erase_mask))); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (window_expired && eng_done) |=> (!busy && erase_mask == '0)); // R8
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !window_expired && other_wr) |=> (!busy && !commit)); // R9
endmodule

bind sector_erase_accum se_acc_chk #(.N_SEC(N_SEC), .WIN(WIN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .se_valid       (se_valid),
  .se_sector      (se_sector),
  .other_wr       (other_wr),
  .eng_done       (eng_done),
  .busy           (busy),
  .window_expired (window_expired),
  .commit         (commit),
  .erase_mask     (erase_mask)
);

// File: tb/sector_erase_accum_tb.sv
module sector_erase_accum_tb;
  localparam int N_SEC = 8;
  localparam int WIN   = 5;
  localparam int SEC_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             se_valid;
  logic [SEC_W-1:0] se_sector;
  logic             other_wr;
  logic             eng_done;
  logic             busy;
  logic             window_expired;
  logic             commit;
  logic [N_SEC-1:0] erase_mask;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  sector_erase_accum #(.N_SEC(N_SEC), .WIN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .se_valid(se_valid), .se_sector(se_sector),
    .other_wr(other_wr), .eng_done(eng_done), .busy(busy),
    .window_expired(window_expired), .commit(commit), .erase_mask(erase_mask)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe(input int s);
    se_valid  = 1'b1;
    se_sector = SEC_W'(s);
    cyc();
    se_valid  = 1'b0;
  endtask

  task automatic finish_erase();
    eng_done = 1'b1;
    cyc();
    eng_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int acc;
    int status;
    rst_n = 1'b0; se_valid = 1'b0; se_sector = '0; other_wr = 1'b0; eng_done = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    status = {busy, window_expired, commit};
    chk(status == 0 && erase_mask == 0, "R1", status, 0);

    // R10: idle other write and done ignored
    other_wr = 1'b1; eng_done = 1'b1; cyc(); other_wr = 1'b0; eng_done = 1'b0;
    chk(!busy && erase_mask == 0, "R10", busy, 0);

    // Sweep every non-empty mask
    for (int m = 1; m < (1 << N_SEC); m++) begin
      bit first = 1'b1;
      int gap = m % WIN;
      acc = 0;
      for (int s = 0; s < N_SEC; s++) begin
        if (m[s]) begin
          if (!first) repeat (gap) cyc();
          strobe(s);
          acc |= (1 << s);
          if (first) chk(busy && !window_expired, "R2", {busy, window_expired}, 2'b10);
          chk(erase_mask == acc[N_SEC-1:0], "R3", erase_mask, acc);
          first = 1'b0;
        end
      end
      for (int k = 1; k < WIN; k++) begin
        if (k == 2) eng_done = 1'b1;   // R10: done during collection ignored
        cyc();
        eng_done = 1'b0;
        chk(!window_expired && !commit && busy, "R4", {window_expired, commit}, 0);
      end
      cyc();
      chk(commit && window_expired, "R5", {commit, window_expired}, 2'b11);
      chk(erase_mask == m[N_SEC-1:0], "R6", erase_mask, m);
      cyc();
      chk(!commit && window_expired, "R6", commit, 0);
      se_valid = 1'b1; se_sector = SEC_W'(~m); other_wr = 1'b1;
      cyc();
      se_valid = 1'b0; other_wr = 1'b0;
      chk(erase_mask == m[N_SEC-1:0] && window_expired && busy, "R7", erase_mask, m);
      finish_erase();
      chk(!busy && !window_expired && erase_mask == 0, "R8", {busy, erase_mask}, 0);
    end

    // Cancel at each window position, with and without a simultaneous strobe
    for (int k = 0; k < WIN; k++) begin
      for (int both = 0; both < 2; both++) begin
        strobe(2);
        repeat (k) cyc();
        other_wr = 1'b1; se_valid = both[0]; se_sector = 3'd5;
        cyc();
        other_wr = 1'b0; se_valid = 1'b0;
        chk(!busy && erase_mask == 0, "R9", {busy, erase_mask}, 0);
        for (int w = 0; w < WIN + 2; w++) begin
          cyc();
          chk(!commit && !window_expired && !busy, "R9", {commit, busy}, 0);
        end
      end
    end

    // R10: other write together with a strobe in idle still starts
    other_wr = 1'b1; se_valid = 1'b1; se_sector = 3'd7;
    cyc();
    other_wr = 1'b0; se_valid = 1'b0;
    chk(busy && erase_mask == 8'h80, "R10", erase_mask, 8'h80);
    repeat (WIN) cyc();
    chk(commit && erase_mask == 8'h80, "R4", erase_mask, 8'h80);
    finish_erase();
    chk(!busy, "R8", busy, 0);

    done_flag = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule